// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block carries out one atomic read-modify-write on a simple synchronous memory port. A request holds an access size, a base register value with a signed 16-bit displacement, a 32-bit operation selector, the source register value and the value of the fixed comparison register R0. The sequencer decodes the request, reads memory, computes the new value, writes it back and then returns a register writeback. Memory stays locked from the read cycle to the end of the write.

Five operations are supported: add, or, and, xor, and exchange, plus a compare-exchange against R0. A flag bit in the selector asks for the old memory value to be returned to the source register. The two swapping operations must have that flag set. Illegal sizes, unknown selectors and unaligned addresses finish at once with an error code and never touch memory. The owner of the register file applies the returned writebacks. Arbitration between several memory masters is left to the logic that watches the lock output.

Top module: `amo_unit`

## Requirements
- R1: After reset the unit is idle. `req_ready` is 1, and `mem_rd_en`, `mem_wr_en`, `mem_lock` and `rsp_valid` are all 0.
- R2: Size code `req_size` uses 0 = 32-bit word, 1 = 16-bit, 2 = 8-bit, 3 = 64-bit doubleword. Codes 1 and 2 end with `rsp_err` = 1 on the first cycle after acceptance, with no memory access.
- R3: The selector `req_imm` with its bit 0 cleared picks the operation: 0x00 add, 0x40 or, 0x50 and, 0xa0 xor. The memory operand is combined with the source value and the result is written back.
- R4: Exchange is 0xe1 and compare-exchange is 0xf1. Any other selector ends with `rsp_err` = 2 on the first cycle after acceptance, with no memory access. This includes a selector with bits 31..8 non-zero, and 0xe0 or 0xf0 (fetch flag clear). A size error takes priority over this error.
- R5: The memory byte address is `req_base` plus `req_offset` sign-extended. The same address is used for the read and the write.
- R6: A word address with bits 1..0 non-zero, or a doubleword address with bits 2..0 non-zero, ends with `rsp_err` = 3 on the first cycle after acceptance, with no memory access. This error ranks below the size error and the selector error.
- R7: A completing operation reads in the first cycle after acceptance, writes in the third, and asserts `rsp_valid` in the fourth. `mem_lock` is high in exactly these first three cycles.
- R8: For a word operation only bits 31..0 take part. Bits 63..32 of `mem_wdata` are zero, and returned values are zero-extended to 64 bits.
- R9: When bit 0 of the selector is set on add, or, and, or xor, `rsp_src_we` is 1 and `rsp_src_val` is the memory value before the operation. When the bit is clear, neither writeback enable is raised.
- R10: Exchange writes the source value to memory and returns the old memory value through `rsp_src_we`/`rsp_src_val`.
- R11: When memory equals R0 (low 32 bits for a word), compare-exchange writes the source value. It always returns the old value through `rsp_r0_we`/`rsp_r0_val`, never through the source writeback.
- R12: When memory differs from R0, compare-exchange issues no write. `mem_lock` is high for the read cycle and the cycle after it only, and `rsp_valid` comes in the third cycle after acceptance.
- R13: `req_ready` is 1 only while idle. A request presented while the unit is busy is ignored and causes no extra memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| req_size | input | 2 | Access size code |
| req_base | input | 64 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_imm | input | 32 | Operation selector |
| req_src | input | 64 | Source register value |
| req_r0 | input | 64 | Comparison register value |
| mem_rd_en | output | 1 | Memory read strobe; data returns next cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_dword | output | 1 | 1 for 64-bit access, 0 for word access on bits 31..0 |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid the cycle after `mem_rd_en` |
| mem_lock | output | 1 | Exclusive hold of the memory location |
| rsp_valid | output | 1 | Single-cycle completion pulse |
| rsp_err | output | 2 | 0 ok, 1 size, 2 selector, 3 alignment |
| rsp_src_we | output | 1 | Write `rsp_src_val` into the source register |
| rsp_src_val | output | 64 | Old memory value for the source register |
| rsp_r0_we | output | 1 | Write `rsp_r0_val` into R0 |
| rsp_r0_val | output | 64 | Old memory value for R0 |

## Verification
The embedded properties check protocol shape on every cycle. Every memory strobe falls inside the lock window, and every write comes two cycles after a read to the same address. Word writes carry a zero upper half, doubleword accesses are aligned, responses last one cycle, and an error response always comes straight from the idle state. Only the directed scenarios can show that the data are right: the arithmetic results, which register receives the old value, the match versus mismatch choice of compare-exchange, the ordering of the error codes, and the exact latencies and lock lengths.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_MODIFY = 3'd2,
    ST_WRITE  = 3'd3,
    ST_DONE   = 3'd4
  } amo_state_e;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_OR   = 3'd1,
    OP_AND  = 3'd2,
    OP_XOR  = 3'd3,
    OP_SWAP = 3'd4,
    OP_CAS  = 3'd5
  } amo_op_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_SIZE  = 2'd1,
    ERR_OP    = 2'd2,
    ERR_ALIGN = 2'd3
  } amo_err_e;

  localparam logic [1:0] SZ_WORD  = 2'd0;
  localparam logic [1:0] SZ_HALF  = 2'd1;
  localparam logic [1:0] SZ_BYTE  = 2'd2;
  localparam logic [1:0] SZ_DWORD = 2'd3;

  // selector values with the fetch flag removed (imm[7:1])
  localparam logic [6:0] SEL_ADD  = 7'h00;
  localparam logic [6:0] SEL_OR   = 7'h20;
  localparam logic [6:0] SEL_AND  = 7'h28;
  localparam logic [6:0] SEL_XOR  = 7'h50;
  localparam logic [6:0] SEL_SWAP = 7'h70;
  localparam logic [6:0] SEL_CAS  = 7'h78;

  typedef struct packed {
    amo_op_e  op;
    logic     fetch;
    logic     dword;
    amo_err_e err;
  } amo_dec_t;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [1:0]       size,
  input  logic [IMM_W-1:0] imm,
  input  logic [2:0]       addr_lo,
  output amo_dec_t         dec
);

  localparam int SEL_LSB = 1;

  amo_op_e  op_d;
  logic     op_bad;
  logic     size_bad;
  logic     align_bad;
  logic     fetch;
  logic     is_dw;

  assign fetch    = imm[0];
  assign is_dw    = (size == SZ_DWORD);
  assign size_bad = (size == SZ_HALF) || (size == SZ_BYTE);

  always_comb begin
    op_d   = OP_ADD;
    op_bad = 1'b0;
    if (imm[IMM_W-1:8] != '0) begin
      op_bad = 1'b1;
    end else begin
      unique case (imm[7:SEL_LSB])
        SEL_ADD:  op_d = OP_ADD;
        SEL_OR:   op_d = OP_OR;
        SEL_AND:  op_d = OP_AND;
        SEL_XOR:  op_d = OP_XOR;
        SEL_SWAP: begin op_d = OP_SWAP; op_bad = !fetch; end
        SEL_CAS:  begin op_d = OP_CAS;  op_bad = !fetch; end
        default:  op_bad = 1'b1;
      endcase
    end
  end

  assign align_bad = is_dw ? (addr_lo != 3'b000) : (addr_lo[1:0] != 2'b00);

  always_comb begin
    dec.op    = op_d;
    dec.fetch = fetch;
    dec.dword = is_dw;
    if (size_bad)       dec.err = ERR_SIZE;
    else if (op_bad)    dec.err = ERR_OP;
    else if (align_bad) dec.err = ERR_ALIGN;
    else                dec.err = ERR_NONE;
  end

endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  amo_op_e           op,
  input  logic              dword,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] r0,
  output logic [DATA_W-1:0] new_val,
  output logic              match
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] keep_mask;

  always_comb begin
    unique case (op)
      OP_ADD:  raw = old_val + src;
      OP_OR:   raw = old_val | src;
      OP_AND:  raw = old_val & src;
      OP_XOR:  raw = old_val ^ src;
      default: raw = src;
    endcase
  end

  assign keep_mask = dword ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  assign new_val   = raw & keep_mask;
  assign match     = ((old_val ^ r0) & keep_mask) == '0;

endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  amo_dec_t          dec,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] r0,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic              mem_dword,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_lock,
  output amo_op_e           alu_op,
  output logic [DATA_W-1:0] alu_old,
  output logic [DATA_W-1:0] alu_src,
  output logic [DATA_W-1:0] alu_r0,
  input  logic [DATA_W-1:0] alu_new,
  input  logic              alu_match,
  output logic              rsp_valid,
  output logic [1:0]        rsp_err,
  output logic              rsp_src_we,
  output logic [DATA_W-1:0] rsp_src_val,
  output logic              rsp_r0_we,
  output logic [DATA_W-1:0] rsp_r0_val
);

  localparam int HALF_W = DATA_W / 2;

  amo_state_e        st_q, st_d;
  amo_op_e           op_q;
  logic              fetch_q, dword_q;
  amo_err_e          err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] src_q, r0_q, old_q, new_q;

  logic accept, ld_req, ld_mod;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign ld_req    = accept;
  assign ld_mod    = (st_q == ST_MODIFY);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (accept) st_d = (dec.err == ERR_NONE) ? ST_READ : ST_DONE;
      ST_READ:   st_d = ST_MODIFY;
      ST_MODIFY: st_d = (op_q == OP_CAS && !alu_match) ? ST_DONE : ST_WRITE;
      ST_WRITE:  st_d = ST_DONE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_ADD;
      fetch_q <= 1'b0;
      dword_q <= 1'b0;
      err_q   <= ERR_NONE;
      addr_q  <= '0;
      src_q   <= '0;
      r0_q    <= '0;
    end else if (ld_req) begin
      op_q    <= dec.op;
      fetch_q <= dec.fetch;
      dword_q <= dec.dword;
      err_q   <= dec.err;
      addr_q  <= addr;
      src_q   <= src;
      r0_q    <= r0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q <= '0;
      new_q <= '0;
    end else if (ld_mod) begin
      old_q <= alu_old;
      new_q <= alu_new;
    end
  end

  assign alu_op  = op_q;
  assign alu_old = dword_q ? mem_rdata : {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};
  assign alu_src = src_q;
  assign alu_r0  = r0_q;

  assign mem_rd_en = (st_q == ST_READ);
  assign mem_wr_en = (st_q == ST_WRITE);
  assign mem_lock  = (st_q == ST_READ) || (st_q == ST_MODIFY) || (st_q == ST_WRITE);
  assign mem_dword = dword_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = new_q;

  assign rsp_valid   = (st_q == ST_DONE);
  assign rsp_err     = err_q;
  assign rsp_src_we  = rsp_valid && (err_q == ERR_NONE) && fetch_q && (op_q != OP_CAS);
  assign rsp_r0_we   = rsp_valid && (err_q == ERR_NONE) && (op_q == OP_CAS);
  assign rsp_src_val = old_q;
  assign rsp_r0_val  = old_q;

  // R7: memory strobes only inside the lock window
  p_strobe_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> mem_lock);
  // R7 / R5: a write follows its read by two cycles at the same address
  p_write_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($past(mem_rd_en, 2) && mem_addr == $past(mem_addr, 2)));
  // R8: word writes leave the upper half zero
  p_word_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !mem_dword) |-> (mem_wdata[DATA_W-1:HALF_W] == '0));
  // R6: doubleword accesses are naturally aligned
  p_dword_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && mem_dword) |-> (mem_addr[2:0] == 3'b000));
  // R2 / R4 / R6: error completions come straight from idle
  p_err_from_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err != 2'd0) |-> $past(req_ready));
  // R13: one-cycle response, never while ready
  p_rsp_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!req_ready ##1 !rsp_valid));
  // R11 / R12: at most one writeback target
  p_one_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_src_we && rsp_r0_we));

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 16,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic [DATA_W-1:0] req_src,
  input  logic [DATA_W-1:0] req_r0,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic              mem_dword,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_lock,
  output logic              rsp_valid,
  output logic [1:0]        rsp_err,
  output logic              rsp_src_we,
  output logic [DATA_W-1:0] rsp_src_val,
  output logic              rsp_r0_we,
  output logic [DATA_W-1:0] rsp_r0_val
);

  localparam int EXT_W = DATA_W - OFF_W;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [DATA_W-1:0] eff_addr;
  assign eff_addr = req_base + {{EXT_W{req_offset[OFF_W-1]}}, req_offset};

  amo_dec_t dec;
  amo_decode #(.IMM_W(IMM_W)) u_decode (
    .size    (req_size),
    .imm     (req_imm),
    .addr_lo (eff_addr[2:0]),
    .dec     (dec)
  );

  amo_op_e           alu_op;
  logic [DATA_W-1:0] alu_old, alu_src, alu_r0, alu_new;
  logic              alu_match;

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (alu_op),
    .dword   (mem_dword),
    .old_val (alu_old),
    .src     (alu_src),
    .r0      (alu_r0),
    .new_val (alu_new),
    .match   (alu_match)
  );

  amo_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .dec         (dec),
    .addr        (eff_addr[ADDR_W-1:0]),
    .src         (req_src),
    .r0          (req_r0),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .mem_dword   (mem_dword),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_lock    (mem_lock),
    .alu_op      (alu_op),
    .alu_old     (alu_old),
    .alu_src     (alu_src),
    .alu_r0      (alu_r0),
    .alu_new     (alu_new),
    .alu_match   (alu_match),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_src_we  (rsp_src_we),
    .rsp_src_val (rsp_src_val),
    .rsp_r0_we   (rsp_r0_we),
    .rsp_r0_val  (rsp_r0_val)
  );

endmodule

// File: tb/amo_unit_tb.sv
module amo_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [63:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_imm = '0;
  logic [63:0] req_src = '0;
  logic [63:0] req_r0 = '0;
  logic [63:0] mem_rdata = '0;
  logic        req_ready, mem_rd_en, mem_wr_en, mem_dword, mem_lock;
  logic [63:0] mem_addr, mem_wdata;
  logic        rsp_valid, rsp_src_we, rsp_r0_we;
  logic [1:0]  rsp_err;
  logic [63:0] rsp_src_val, rsp_r0_val;

  always #2.5 clk = ~clk;

  amo_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_base(req_base), .req_offset(req_offset),
    .req_imm(req_imm), .req_src(req_src), .req_r0(req_r0),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_dword(mem_dword),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_lock(mem_lock), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_src_we(rsp_src_we), .rsp_src_val(rsp_src_val),
    .rsp_r0_we(rsp_r0_we), .rsp_r0_val(rsp_r0_val)
  );

  // memory model: 32 doublewords, word accesses pick a half with addr[2]
  logic [63:0] mem [0:31];
  int lock_cnt = 0, rd_cnt = 0, wr_cnt = 0;

  always @(posedge clk) begin
    if (mem_rd_en) begin
      if (mem_dword) mem_rdata <= mem[mem_addr[7:3]];
      else mem_rdata <= {32'h0, mem_addr[2] ? mem[mem_addr[7:3]][63:32] : mem[mem_addr[7:3]][31:0]};
    end
    if (mem_wr_en) begin
      if (mem_dword) mem[mem_addr[7:3]] <= mem_wdata;
      else if (mem_addr[2]) mem[mem_addr[7:3]][63:32] <= mem_wdata[31:0];
      else mem[mem_addr[7:3]][31:0] <= mem_wdata[31:0];
    end
    if (mem_lock)  lock_cnt <= lock_cnt + 1;
    if (mem_rd_en) rd_cnt <= rd_cnt + 1;
    if (mem_wr_en) wr_cnt <= wr_cnt + 1;
  end

  int errors = 0, checks = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // results of the last operation
  int lat, d_lock, d_rd, d_wr;
  logic [1:0]  r_err;
  logic        r_swe, r_rwe;
  logic [63:0] r_sval, r_rval;

  task automatic run_op(input logic [1:0] sz, input logic [63:0] base,
                        input logic [15:0] off, input logic [31:0] imm,
                        input logic [63:0] src, input logic [63:0] r0);
    int l0, rd0, wr0;
    @(negedge clk);
    req_size = sz; req_base = base; req_offset = off; req_imm = imm;
    req_src = src; req_r0 = r0; req_valid = 1'b1;
    l0 = lock_cnt; rd0 = rd_cnt; wr0 = wr_cnt;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    r_err = rsp_err; r_swe = rsp_src_we; r_rwe = rsp_r0_we;
    r_sval = rsp_src_val; r_rval = rsp_r0_val;
    @(negedge clk);
    d_lock = lock_cnt - l0; d_rd = rd_cnt - rd0; d_wr = wr_cnt - wr0;
  endtask

  task automatic t_reset();
    chk("R1 ready", {63'd0, req_ready}, 64'd1);
    chk("R1 rd", {63'd0, mem_rd_en}, 64'd0);
    chk("R1 wr", {63'd0, mem_wr_en}, 64'd0);
    chk("R1 lock", {63'd0, mem_lock}, 64'd0);
    chk("R1 rsp", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic t_add_dword();
    mem[1] = 64'h0000_0001_FFFF_FFFF;
    // base 0x100 + (-0xF8) = 0x08
    run_op(2'd3, 64'h100, 16'hFF08, 32'h00, 64'h1, 64'h0);
    chk("R3 add dword", mem[1], 64'h0000_0002_0000_0000);
    chk("R5 neg offset addr", {59'd0, d_rd[4:0]}, 64'd1);
    chk("R9 no writeback", {62'd0, r_swe, r_rwe}, 64'd0);
    chk("R7 latency", lat, 4);
    chk("R7 lock cycles", d_lock, 3);
    chk("R7 one write", d_wr, 1);
    chk("R3 err none", {62'd0, r_err}, 64'd0);
  endtask

  task automatic t_word_ops();
    mem[2] = 64'hAAAA_5555_F0F0_00FF;
    run_op(2'd0, 64'h10, 16'h0004, 32'h41, 64'hFFFF_FFFF_0000_0F00, 64'h0);
    chk("R3 or word high half", mem[2], 64'hAAAA_5F55_F0F0_00FF);
    chk("R9 fetch or", r_sval, 64'h0000_0000_AAAA_5555);
    chk("R9 fetch we", {63'd0, r_swe}, 64'd1);
    run_op(2'd0, 64'h10, 16'h0000, 32'h51, 64'h1234_5678_0F0F_0F0F, 64'h0);
    chk("R8 and word low half", mem[2], 64'hAAAA_5F55_0000_000F);
    chk("R8 zero extend", r_sval, 64'h0000_0000_F0F0_00FF);
    run_op(2'd0, 64'h10, 16'h0000, 32'hA0, 64'h0000_0000_FFFF_FFFF, 64'h0);
    chk("R3 xor word", mem[2], 64'hAAAA_5F55_FFFF_FFF0);
    chk("R9 xor no fetch", {62'd0, r_swe, r_rwe}, 64'd0);
    mem[3] = 64'h0;
    run_op(2'd0, 64'h18, 16'h0000, 32'h01, 64'h5, 64'h0);
    run_op(2'd0, 64'h18, 16'h0000, 32'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    chk("R8 word wrap", mem[3], 64'h0000_0000_0000_0004);
  endtask

  task automatic t_swap();
    mem[4] = 64'hDEAD_BEEF_0123_4567;
    run_op(2'd3, 64'h20, 16'h0, 32'hE1, 64'h1111_2222_3333_4444, 64'h0);
    chk("R10 swap mem", mem[4], 64'h1111_2222_3333_4444);
    chk("R10 swap old", r_sval, 64'hDEAD_BEEF_0123_4567);
    chk("R10 swap we", {62'd0, r_swe, r_rwe}, 64'd2);
  endtask

  task automatic t_cas();
    mem[5] = 64'h0000_0000_0000_0077;
    run_op(2'd3, 64'h28, 16'h0, 32'hF1, 64'h99, 64'h77);
    chk("R11 cas match mem", mem[5], 64'h99);
    chk("R11 cas r0 old", r_rval, 64'h77);
    chk("R11 cas we", {62'd0, r_swe, r_rwe}, 64'd1);
    mem[6] = 64'h5555_0000_CAFE_0001;
    run_op(2'd0, 64'h30, 16'h0, 32'hF1, 64'hABCD, 64'hFFFF_FFFF_CAFE_0001);
    chk("R11 cas word match low only", mem[6], 64'h5555_0000_0000_ABCD);
    chk("R11 cas word old zext", r_rval, 64'h0000_0000_CAFE_0001);
    run_op(2'd3, 64'h30, 16'h0, 32'hF1, 64'h1, 64'h2);
    chk("R12 mismatch mem kept", mem[6], 64'h5555_0000_0000_ABCD);
    chk("R12 mismatch no write", d_wr, 0);
    chk("R12 mismatch lock", d_lock, 2);
    chk("R12 mismatch latency", lat, 3);
    chk("R12 mismatch r0", r_rval, 64'h5555_0000_0000_ABCD);
    chk("R12 mismatch we", {62'd0, r_swe, r_rwe}, 64'd1);
  endtask

  task automatic err_case(input string tag, input logic [1:0] sz, input logic [63:0] base,
                          input logic [31:0] imm, input logic [1:0] exp_err);
    mem[7] = 64'h7777;
    run_op(sz, base, 16'h0, imm, 64'h1, 64'h0);
    chk({tag, " code"}, {62'd0, r_err}, {62'd0, exp_err});
    chk({tag, " latency"}, lat, 1);
    chk({tag, " no access"}, d_rd + d_wr + d_lock, 0);
    chk({tag, " no writeback"}, {62'd0, r_swe, r_rwe}, 64'd0);
    chk({tag, " mem kept"}, mem[7], 64'h7777);
  endtask

  task automatic t_errors();
    err_case("R2 half", 2'd1, 64'h38, 32'h01, 2'd1);
    err_case("R2 byte over bad op", 2'd2, 64'h3A, 32'h13, 2'd1);
    err_case("R4 unknown sel", 2'd3, 64'h38, 32'h10, 2'd2);
    err_case("R4 swap no fetch", 2'd3, 64'h38, 32'hE0, 2'd2);
    err_case("R4 cas no fetch", 2'd0, 64'h38, 32'hF0, 2'd2);
    err_case("R4 high bits", 2'd3, 64'h38, 32'h100, 2'd2);
    err_case("R4 over align", 2'd3, 64'h3C, 32'h02, 2'd2);
    err_case("R6 word misaligned", 2'd0, 64'h3A, 32'h00, 2'd3);
    err_case("R6 dword misaligned", 2'd3, 64'h3C, 32'h00, 2'd3);
  endtask

  task automatic t_busy();
    int rd0, seen_ready;
    mem[8] = 64'h10;
    rd0 = rd_cnt;
    seen_ready = 0;
    @(negedge clk);
    req_size = 2'd3; req_base = 64'h40; req_offset = 16'h0; req_imm = 32'h00;
    req_src = 64'h5; req_valid = 1'b1;
    @(negedge clk);
    req_base = 64'h48; req_src = 64'h100;   // held while busy
    for (int i = 0; i < 3; i++) begin
      if (req_ready) seen_ready++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk("R13 response at end", {63'd0, rsp_valid}, 64'd1);
    @(negedge clk);
    chk("R13 ready low busy", seen_ready, 0);
    chk("R13 single read", rd_cnt - rd0, 1);
    chk("R13 first op only", mem[8], 64'h15);
    chk("R13 ready again", {63'd0, req_ready}, 64'd1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_add_dword();
    t_word_ops();
    t_swap();
    t_cas();
    t_errors();
    t_busy();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule